// File: doc/BRIEF.md
# Down-Counting Interval Timer

A 32-bit interval timer reached over a small word-addressed register bus. The counter steps down by one on each tick of a chosen source, where the sources are three external tick-enable strobes. When it passes zero it either reloads from a programmable load value or wraps to all ones. A sticky match flag is raised whenever a counting step lands on the programmed compare value. That flag can be forwarded to an interrupt line.

Software programs a load value and a compare value, picks a tick source and a few mode options, and then sets the enable bit. Optional behaviours are: loading the counter when the timer is switched on, overwriting the counter whenever the load value is written, and keeping the counter running while the chip is in stop, wait or debug state. A self-clearing soft-reset bit returns the timer's state to its initial values. The mode bits written together with the soft-reset bit are kept.

Top module: `ivt_timer`

## Requirements
- R1: After the synchronous reset, the register reads are: control 0, status 0, load 0xFFFFFFFF, compare 0, count 0. The interrupt output is low.
- R2: The word index is taken from bus_addr[4:2]: 0 control, 1 status, 2 load, 3 compare, 4 count. A read returns the pre-edge register value on bus_rdata at the next clock edge. Indices 5 to 7 read 0. Only control bits 25:24, 21, 19:16 and 3:0 are stored; every other control bit reads 0.
- R3: While control bit 0 is 1, the counter decrements by one on each clock where the tick selected by control bits 25:24 is high. The selection is 0 = none, 1 = tick_per, 2 = tick_hf, 3 = tick_lf. While bit 0 is 0 the counter holds.
- R4: A tick that finds the counter at 0 loads the load value when control bit 3 is 1. When bit 3 is 0, the same tick sets the counter to 0xFFFFFFFF.
- R5: A control write that sets bits 0 and 1 while bit 0 was 0 copies the load value into the counter at that write's clock edge.
- R6: With control bit 17 set, a load write also puts the written value into the counter at the same edge. With bit 17 clear, a load write leaves the counter unchanged.
- R7: A control write with bit 16 set stores the written bits. One edge later it clears the counter, the compare value and the status flag, sets the load value to 0xFFFFFFFF, and clears bit 16. All other written control bits are kept.
- R8: Status bit 0 is set by a counting step whose new count equals the compare value. It stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R9: The irq output equals (status bit 0 AND control bit 2), delayed by one clock.
- R10: Counting halts while mode_stop is high and control bit 21 is 0. It also halts while mode_wait is high and bit 19 is 0, and while mode_debug is high and bit 18 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_per | input | 1 | Peripheral-rate tick strobe |
| tick_hf | input | 1 | High-frequency reference tick strobe |
| tick_lf | input | 1 | Low-frequency reference tick strobe |
| mode_stop | input | 1 | Chip is in stop state |
| mode_wait | input | 1 | Chip is in wait state |
| mode_debug | input | 1 | Chip is in debug state |
| irq | output | 1 | Compare interrupt, registered |

## Verification
Results are due at different edges, and the bench samples each one where it is due:

- A register write, an enable-load or a load overwrite takes effect at the edge that accepts the bus cycle.
- A tick moves the counter at the edge where the tick is high.
- Soft reset acts one edge after its write.
- Read data and irq each appear one edge after the state they reflect.

A behavioural model in the bench advances on every rising edge, using the inputs that were driven half a cycle earlier. Both irq and bus_rdata are compared one nanosecond after each edge. Directed reads put fixed expected values on top of this. The tick strobes are driven for exact cycle counts, so every expected count is known in advance.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // word indices on bus_addr[4:2]
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_LOAD = 2;
  localparam int IDX_CMP  = 3;
  localparam int IDX_CNT  = 4;

  // control bit positions
  localparam int B_EN       = 0;
  localparam int B_ENLD     = 1;
  localparam int B_IRQEN    = 2;
  localparam int B_RELOAD   = 3;
  localparam int B_SRST     = 16;
  localparam int B_OVW      = 17;
  localparam int B_RUN_DBG  = 18;
  localparam int B_RUN_WAIT = 19;
  localparam int B_RUN_STOP = 21;
  localparam int B_SRC_LO   = 24;

  localparam int SRC_W     = 2;
  localparam int NUM_SRC   = 1 << SRC_W;
  localparam int NUM_MODES = 3;
endpackage

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
  import ivt_pkg::*;
(
  input  logic [SRC_W-1:0]     src,
  input  logic                 run_en,
  input  logic                 srst_act,
  input  logic [NUM_MODES-1:0] allow,     // {debug, wait, stop}
  input  logic                 tick_per,
  input  logic                 tick_hf,
  input  logic                 tick_lf,
  input  logic                 mode_stop,
  input  logic                 mode_wait,
  input  logic                 mode_debug,
  output logic                 tick_go
);
  logic [NUM_SRC-1:0]   src_vec;
  logic [NUM_MODES-1:0] mode_act;
  logic [NUM_MODES-1:0] mode_blk;

  assign src_vec  = {tick_lf, tick_hf, tick_per, 1'b0};
  assign mode_act = {mode_debug, mode_wait, mode_stop};

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    assign mode_blk[i] = mode_act[i] & ~allow[i];
  end

  assign tick_go = src_vec[src] & run_en & ~srst_act & ~(|mode_blk);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst_act,
  input  logic              ld_now,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              tick_go,
  input  logic              reload_en,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              hit
);
  logic [DATA_W-1:0] step_val;

  always_comb begin
    if (cnt_q == '0) step_val = reload_en ? load_q : '1;
    else             step_val = cnt_q - 1'b1;
  end

  assign hit = tick_go & ~ld_now & (step_val == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (srst_act) cnt_q <= '0;
    else if (ld_now)   cnt_q <= ld_val;
    else if (tick_go)  cnt_q <= step_val;
  end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [DATA_W-1:0]    cnt,
  input  logic                 hit,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq,
  output logic                 flag_q,
  output logic [DATA_W-1:0]    load_q,
  output logic [DATA_W-1:0]    cmp_q,
  output logic                 ld_now,
  output logic [DATA_W-1:0]    ld_val,
  output logic                 srst_act,
  output logic                 run_en,
  output logic                 reload_en,
  output logic [SRC_W-1:0]     src,
  output logic [NUM_MODES-1:0] allow
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'(NUM_SRC - 1) << B_SRC_LO) |
      (DATA_W'(1) << B_RUN_STOP) | (DATA_W'(1) << B_RUN_WAIT) |
      (DATA_W'(1) << B_RUN_DBG)  | (DATA_W'(1) << B_OVW) |
      (DATA_W'(1) << B_SRST)     | (DATA_W'(1) << B_RELOAD) |
      (DATA_W'(1) << B_IRQEN)    | (DATA_W'(1) << B_ENLD) |
      (DATA_W'(1) << B_EN);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        addr_lo_unused;
  logic              wr_acc, rd_acc;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic              en_load_evt, ovw_evt;
  logic [DATA_W-1:0] rd_mux;

  assign idx            = bus_addr[ADDR_W-1:2];
  assign addr_lo_unused = bus_addr[1:0];
  assign wr_acc  = bus_sel & bus_wr;
  assign rd_acc  = bus_sel & ~bus_wr;
  assign wr_ctrl = wr_acc && (idx == IDX_W'(IDX_CTRL));
  assign wr_stat = wr_acc && (idx == IDX_W'(IDX_STAT));
  assign wr_load = wr_acc && (idx == IDX_W'(IDX_LOAD));
  assign wr_cmp  = wr_acc && (idx == IDX_W'(IDX_CMP));
  assign ctrl_d  = bus_wdata & CTRL_MASK;

  assign en_load_evt = wr_ctrl & ctrl_d[B_EN] & ctrl_d[B_ENLD] & ~ctrl_q[B_EN];
  assign ovw_evt     = wr_load & ctrl_q[B_OVW];
  assign ld_now      = en_load_evt | ovw_evt;
  assign ld_val      = ovw_evt ? bus_wdata : load_q;

  assign srst_act  = ctrl_q[B_SRST];
  assign run_en    = ctrl_q[B_EN];
  assign reload_en = ctrl_q[B_RELOAD];
  assign src       = ctrl_q[B_SRC_LO +: SRC_W];
  assign allow     = {ctrl_q[B_RUN_DBG], ctrl_q[B_RUN_WAIT], ctrl_q[B_RUN_STOP]};

  always_comb begin
    case (idx)
      IDX_W'(IDX_CTRL): rd_mux = ctrl_q;
      IDX_W'(IDX_STAT): rd_mux = {{(DATA_W-1){1'b0}}, flag_q};
      IDX_W'(IDX_LOAD): rd_mux = load_q;
      IDX_W'(IDX_CMP):  rd_mux = cmp_q;
      IDX_W'(IDX_CNT):  rd_mux = cnt;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      load_q    <= '1;
      cmp_q     <= '0;
      flag_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q <= ctrl_d;
      else if (srst_act) ctrl_q[B_SRST] <= 1'b0;

      if (srst_act) begin
        load_q <= '1;
        cmp_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (wr_load) load_q <= bus_wdata;
        if (wr_cmp)  cmp_q  <= bus_wdata;
        if (hit)                         flag_q <= 1'b1;
        else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
      end

      irq <= flag_q & ctrl_q[B_IRQEN];
      if (rd_acc) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_per,
  input  logic              tick_hf,
  input  logic              tick_lf,
  input  logic              mode_stop,
  input  logic              mode_wait,
  input  logic              mode_debug,
  output logic              irq
);
  logic [DATA_W-1:0]    cnt_q, load_q, cmp_q, ld_val;
  logic                 flag_q, ld_now, srst_act, run_en, reload_en;
  logic                 tick_go, hit;
  logic [SRC_W-1:0]     src;
  logic [NUM_MODES-1:0] allow;

  ivt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q), .hit(hit),
    .bus_rdata(bus_rdata), .irq(irq), .flag_q(flag_q), .load_q(load_q),
    .cmp_q(cmp_q), .ld_now(ld_now), .ld_val(ld_val), .srst_act(srst_act),
    .run_en(run_en), .reload_en(reload_en), .src(src), .allow(allow)
  );

  ivt_tick_sel u_tick (
    .src(src), .run_en(run_en), .srst_act(srst_act), .allow(allow),
    .tick_per(tick_per), .tick_hf(tick_hf), .tick_lf(tick_lf),
    .mode_stop(mode_stop), .mode_wait(mode_wait), .mode_debug(mode_debug),
    .tick_go(tick_go)
  );

  ivt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .srst_act(srst_act), .ld_now(ld_now),
    .ld_val(ld_val), .tick_go(tick_go), .reload_en(reload_en),
    .load_q(load_q), .cmp_q(cmp_q), .cnt_q(cnt_q), .hit(hit)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  widx,
  input logic              wbit0,
  input logic [DATA_W-1:0] cnt,
  input logic              flag,
  input logic              ie,
  input logic              irq,
  input logic              tick_go,
  input logic              ld_now,
  input logic [DATA_W-1:0] ld_val,
  input logic              srst_act
);
  logic clr_wr, ctrl_wr;
  assign clr_wr  = bus_sel & bus_wr & (widx == IDX_W'(1)) & wbit0;
  assign ctrl_wr = bus_sel & bus_wr & (widx == IDX_W'(0));

  p_cnt_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_go && !ld_now && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_go && !ld_now && !srst_act) |=> cnt == $past(cnt));

  p_ld_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_now && !srst_act) |=> cnt == $past(ld_val));

  p_srst_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (srst_act && !ctrl_wr) |=> (cnt == '0 && !flag && !srst_act));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr && !srst_act) |=> flag);

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq == ($past(flag) && $past(ie)));
endmodule

bind ivt_timer ivt_timer_chk #(.DATA_W(DATA_W), .IDX_W(ADDR_W-2)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .widx(bus_addr[ADDR_W-1:2]), .wbit0(bus_wdata[0]), .cnt(cnt_q),
  .flag(flag_q), .ie(u_regs.ctrl_q[2]), .irq(irq), .tick_go(tick_go),
  .ld_now(ld_now), .ld_val(ld_val), .srst_act(srst_act)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_per = 1'b0, tick_hf = 1'b0, tick_lf = 1'b0;
  logic        mode_stop = 1'b0, mode_wait = 1'b0, mode_debug = 1'b0;
  logic        irq;

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ivt_timer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_per(tick_per), .tick_hf(tick_hf), .tick_lf(tick_lf),
    .mode_stop(mode_stop), .mode_wait(mode_wait), .mode_debug(mode_debug),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctrl, m_load, m_cmp, m_cnt, m_rdata;
  logic        m_flag, m_irq;

  always @(posedge clk) begin
    logic [31:0] n_ctrl, n_load, n_cmp, n_cnt, wdm, ldv, step;
    logic        n_flag, tk, go, ld, hit, blocked, w, srst;
    logic [2:0]  widx;
    if (rst) begin
      m_ctrl = 0; m_load = '1; m_cmp = 0; m_cnt = 0; m_flag = 0; m_irq = 0; m_rdata = 0;
    end else begin
      widx = bus_addr[4:2];
      w    = bus_sel && bus_wr;
      if (bus_sel && !bus_wr) begin
        case (widx)
          3'd0: m_rdata = m_ctrl;
          3'd1: m_rdata = {31'b0, m_flag};
          3'd2: m_rdata = m_load;
          3'd3: m_rdata = m_cmp;
          3'd4: m_rdata = m_cnt;
          default: m_rdata = 0;
        endcase
      end
      srst = m_ctrl[16];
      case (m_ctrl[25:24])
        2'd0: tk = 0;
        2'd1: tk = tick_per;
        2'd2: tk = tick_hf;
        default: tk = tick_lf;
      endcase
      blocked = (mode_stop && !m_ctrl[21]) || (mode_wait && !m_ctrl[19]) ||
                (mode_debug && !m_ctrl[18]);
      go  = tk && m_ctrl[0] && !srst && !blocked;
      wdm = bus_wdata & 32'h032F000F;
      ld = 0; ldv = 0;
      if (w && widx == 0 && wdm[0] && wdm[1] && !m_ctrl[0]) begin ld = 1; ldv = m_load; end
      if (w && widx == 2 && m_ctrl[17]) begin ld = 1; ldv = bus_wdata; end
      step = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFFFFFF) : m_cnt - 1;
      hit  = go && !ld && (step == m_cmp);
      n_cnt  = srst ? 0 : ld ? ldv : go ? step : m_cnt;
      n_flag = srst ? 0 : hit ? 1 : (w && widx == 1 && bus_wdata[0]) ? 0 : m_flag;
      n_ctrl = (w && widx == 0) ? wdm : srst ? (m_ctrl & ~32'h00010000) : m_ctrl;
      n_load = srst ? 32'hFFFFFFFF : (w && widx == 2) ? bus_wdata : m_load;
      n_cmp  = srst ? 0 : (w && widx == 3) ? bus_wdata : m_cmp;
      m_irq  = m_flag && m_ctrl[2];
      m_ctrl = n_ctrl; m_load = n_load; m_cmp = n_cmp; m_cnt = n_cnt; m_flag = n_flag;
    end
    #1;
    if (!rst) begin
      check({cur_req, " model irq"}, {31'b0, irq}, {31'b0, m_irq});
      check({cur_req, " model rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #2; bus_sel = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic set_tick(input int which, input logic v);
    case (which)
      0: tick_per = v;
      1: tick_hf  = v;
      default: tick_lf = v;
    endcase
  endtask

  task automatic ticks(input int which, input int n);
    @(negedge clk); set_tick(which, 1'b1);
    repeat (n - 1) @(negedge clk);
    @(negedge clk); set_tick(which, 1'b0);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    repeat (2) @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10, A_NONE = 5'h14;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    irq_chk(1'b0, "R1 irq after reset");
    rd_chk(A_CTRL, 32'h0, "R1 ctrl");
    rd_chk(A_STAT, 32'h0, "R1 status");
    rd_chk(A_LOAD, 32'hFFFFFFFF, "R1 load");
    rd_chk(A_CMP, 32'h0, "R1 compare");
    rd_chk(A_CNT, 32'h0, "R1 count");

    cur_req = "R2";
    wr_reg(A_CTRL, 32'hFCD0FFF0);
    rd_chk(A_CTRL, 32'h0, "R2 unstored ctrl bits");
    rd_chk(A_NONE, 32'h0, "R2 unused index");
    wr_reg(A_CMP, 32'h00A55A00);
    rd_chk(A_CMP, 32'h00A55A00, "R2 compare readback");
    wr_reg(A_CMP, 32'h0);

    cur_req = "R5";
    wr_reg(A_LOAD, 32'd100);
    rd_chk(A_CNT, 32'd0, "R6 load write without overwrite");
    wr_reg(A_CTRL, 32'h0100000B);
    rd_chk(A_CNT, 32'd100, "R5 enable-load");

    cur_req = "R3";
    ticks(0, 7);
    rd_chk(A_CNT, 32'd93, "R3 per ticks");
    wr_reg(A_CTRL, 32'h0000000B);
    ticks(0, 5);
    rd_chk(A_CNT, 32'd93, "R3 source off");
    wr_reg(A_CTRL, 32'h0200000B);
    ticks(0, 3);
    ticks(1, 4);
    rd_chk(A_CNT, 32'd89, "R3 hf source");
    wr_reg(A_CTRL, 32'h0300000B);
    ticks(2, 2);
    rd_chk(A_CNT, 32'd87, "R3 lf source");
    wr_reg(A_CTRL, 32'h01000000);
    ticks(0, 4);
    rd_chk(A_CNT, 32'd87, "R3 disabled holds");

    cur_req = "R4";
    wr_reg(A_LOAD, 32'd4);
    wr_reg(A_CTRL, 32'h0100000B);
    ticks(0, 5);
    rd_chk(A_CNT, 32'd4, "R4 reload from load");
    wr_reg(A_CTRL, 32'h01000003);
    ticks(0, 5);
    rd_chk(A_CNT, 32'hFFFFFFFF, "R4 wrap without reload");

    cur_req = "R8";
    rd_chk(A_STAT, 32'd1, "R8 flag set at zero match");
    wr_reg(A_STAT, 32'h0);
    rd_chk(A_STAT, 32'd1, "R8 write zero ignored");
    wr_reg(A_STAT, 32'h1);
    rd_chk(A_STAT, 32'd0, "R8 write one clears");
    wr_reg(A_CMP, 32'hFFFFFFF0);
    ticks(0, 15);
    rd_chk(A_STAT, 32'd1, "R8 match sets flag");
    ticks(0, 3);
    rd_chk(A_STAT, 32'd1, "R8 flag sticky");

    cur_req = "R9";
    irq_chk(1'b0, "R9 irq masked");
    wr_reg(A_CTRL, 32'h01000007);
    irq_chk(1'b1, "R9 irq enabled");
    wr_reg(A_STAT, 32'h1);
    irq_chk(1'b0, "R9 irq drops after clear");

    cur_req = "R6";
    wr_reg(A_CTRL, 32'h01020003);
    wr_reg(A_LOAD, 32'h1234);
    rd_chk(A_CNT, 32'h1234, "R6 load overwrite");

    cur_req = "R10";
    @(negedge clk); mode_stop = 1;
    ticks(0, 5);
    rd_chk(A_CNT, 32'h1234, "R10 stop halts");
    wr_reg(A_CTRL, 32'h01220003);
    ticks(0, 5);
    rd_chk(A_CNT, 32'h122F, "R10 stop allowed");
    @(negedge clk); mode_stop = 0; mode_wait = 1;
    ticks(0, 3);
    rd_chk(A_CNT, 32'h122F, "R10 wait halts");
    wr_reg(A_CTRL, 32'h01260003);
    @(negedge clk); mode_wait = 0; mode_debug = 1;
    ticks(0, 2);
    rd_chk(A_CNT, 32'h122D, "R10 debug allowed");
    @(negedge clk); mode_debug = 0;

    cur_req = "R7";
    wr_reg(A_CTRL, 32'h0101000F);
    rd_chk(A_CTRL, 32'h0101000F, "R7 srst bit visible");
    rd_chk(A_CTRL, 32'h0100000F, "R7 srst self-clears");
    rd_chk(A_CNT, 32'h0, "R7 count cleared");
    rd_chk(A_LOAD, 32'hFFFFFFFF, "R7 load reset");
    rd_chk(A_CMP, 32'h0, "R7 compare cleared");
    rd_chk(A_STAT, 32'h0, "R7 flag cleared");

    cur_req = "R4 R8 free run";
    wr_reg(A_LOAD, 32'd20);
    wr_reg(A_CMP, 32'd7);
    wr_reg(A_CTRL, 32'h0100000E);
    wr_reg(A_CTRL, 32'h0100000F);
    @(negedge clk); tick_per = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = (i % 2) ? A_STAT : A_CNT;
      @(negedge clk); bus_sel = 0;
      if (i % 4 == 3) begin
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_STAT; bus_wdata = 32'h1;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
      end
    end
    @(negedge clk); tick_per = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule